// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Mode and Rewind

This block is a first-in first-out buffer whose write side and read side run on separate clocks. The storage is a register array whose width and depth are parameters; the depth is a power of two. Each side keeps a binary pointer and passes a registered Gray copy of it to the other clock domain through a two-stage synchronizer. The flags in each domain are therefore conservative: a side can report less data or less room than there really is, but never more.

The flag behaviour is chosen while master reset is held. In standard mode the read-side status pin acts as an active-low empty flag, and a word reaches the output register only when the reader asks for it. In fall-through mode the same pin acts as an active-low output-ready flag. The oldest stored word is moved into the output register without a request, and a read request then fetches the next word. The write-side status pin behaves the same way: it is an active-low full flag in standard mode and an active-low input-ready flag in fall-through mode.

Partial reset clears the pointers and the output register but keeps the chosen mode. The rewind input moves the read pointer back to location zero and leaves the write pointer alone, so the data already written can be read a second time. An output-enable input gates the data output to zero. It does not change the flags.

The read side is a three-state machine:
- `RS_IDLE`: no word is held for fall-through. This is the only working state in standard mode.
- `RS_LOADED`: fall-through mode only; a valid word sits on the output.
- `RS_REWIND`: one cycle that follows a sampled rewind.

The transitions are:
- `IDLE->LOADED`: fall-through mode and the memory is not empty.
- `LOADED->LOADED`: a read request while another word is available.
- `LOADED->IDLE`: a read request with no further word available.
- `any->REWIND`: rewind sampled.
- `REWIND->IDLE`: always, on the next cycle.

Top module: `rewind_fifo`

## Requirements
- R1: The mode is captured from `fwft_sel` (0 = standard, 1 = fall-through) only on read and write clock edges while `mrst_n` is low. After reset, changes on `fwft_sel` have no effect on flags or data.
- R2: In standard mode, `stat_rd_n` is 0 when the FIFO is empty and 1 otherwise. `stat_wr_n` is 0 when the FIFO holds DEPTH words and 1 otherwise.
- R3: In fall-through mode, `stat_rd_n` is 0 exactly while a valid word is driven on the output. `stat_wr_n` is 0 while there is room for a write and 1 when the FIFO is full.
- R4: While `mrst_n` is low, both pointers are cleared and the output register becomes all zeros. After master reset the FIFO reads as empty.
- R5: While `prst_n` is low, both pointers are cleared and the output register becomes all zeros. The mode chosen at the last master reset is kept.
- R6: `half_full` is 1 when the word count seen by the write side is greater than DEPTH/2, and 0 otherwise.
- R7: A high `rt` sampled on a rising `rclk` edge sets the read pointer to zero and leaves the write pointer unchanged. In the following cycle `stat_rd_n` shows that nothing is available: 0 in standard mode, 1 in fall-through mode. Reading then returns the stored sequence again from location zero, and later writes continue after the last written location.
- R8: A read takes place only on a rising `rclk` edge with `rd_en` high. Without it, the output word and the read pointer hold.
- R9: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with no read request. A read request then advances to the next word.
- R10: A write while full and a read while empty are ignored. Neither one moves a pointer or changes the stored data.
- R11: `rd_data` is all zeros while `oe` is 0 and equals the output register while `oe` is 1. `oe` has no effect on the flags.
- R12: In both modes, words are read out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock |
| prst_n | input | 1 | Partial reset, active low, keeps the mode |
| fwft_sel | input | 1 | Mode select, sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Rewind the read pointer to location zero |
| oe | input | 1 | Output enable for rd_data |
| rd_data | output | WIDTH | Read data (zero while oe is low) |
| stat_rd_n | output | 1 | Empty flag (standard) or output-ready flag (fall-through), active low |
| stat_wr_n | output | 1 | Full flag (standard) or input-ready flag (fall-through), active low |
| half_full | output | 1 | Count above half of the depth |

## Verification
A read pointer that strays by even one location shows up at once as a wrong word on `rd_data`. It also appears about three read cycles later as a flag mismatch, once the pointer has crossed the synchronizer. The scoreboard catches such a slip the first time the word is compared, and the rewind test replays the whole stored sequence to make sure the write pointer was not disturbed. A wrong mode register is visible on the very first flag sample after reset, because the status pins have opposite polarity in the two modes. A lost output-register clear appears as a non-zero `rd_data` straight after either reset.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_LOADED = 2'd1,
        RS_REWIND = 2'd2
    } rd_state_e;
endpackage

// File: rtl/rwf_gray_xfer.sv
module rwf_gray_xfer #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1;
    logic [PW-1:0] stage2;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of itself and all bits above it
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign bin_out[i] = ^stage2[PW-1:i];
    end
endmodule

// File: rtl/rwf_mem.sv
module rwf_mem #(
    parameter int AW    = 4,
    parameter int WIDTH = 8
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rwf_wside.sv
module rwf_wside #(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [AW:0]   rbin_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          wr_go,
    output logic          stat_wr_n,
    output logic          half_full
);
    import rwf_pkg::*;

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] CAP  = PW'(DEPTH);
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

    fifo_mode_e    mode_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] used;
    logic          full;
    logic          clr;

    assign clr = !mrst_n || !prst_n;

    // mode is captured only while master reset is held
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
        end
    end

    assign used    = wbin - rbin_s;
    assign full    = (used >= CAP);
    assign wr_go   = wr_en && !full;
    assign wbin_nx = wr_go ? wbin + 1'b1 : wbin;

    always_ff @(posedge wclk) begin
        if (clr) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign waddr     = wbin[AW-1:0];
    assign half_full = (used > HALF);
    assign stat_wr_n = (mode_q == MODE_FWFT) ? full : !full;

    // R10
    wr_blocked_chk: assert property (@(posedge wclk) disable iff (clr)
        (wr_en && full) |=> $stable(wbin));

    // R6
    hf_at_full_chk: assert property (@(posedge wclk) disable iff (clr)
        full |-> half_full);
endmodule

// File: rtl/rwf_rside.sv
module rwf_rside #(
    parameter int AW    = 4,
    parameter int WIDTH = 8
) (
    input  logic             rclk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             fwft_sel,
    input  logic             rd_en,
    input  logic             rt,
    input  logic [AW:0]      wbin_s,
    input  logic [WIDTH-1:0] mem_q,
    output logic [AW:0]      rgray,
    output logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rd_q,
    output logic             stat_rd_n
);
    import rwf_pkg::*;

    localparam int PW = AW + 1;

    fifo_mode_e    mode_q;
    rd_state_e     state;
    rd_state_e     state_nx;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic          mem_empty;
    logic          load;
    logic          clr;
    logic          fwft;

    assign clr       = !mrst_n || !prst_n;
    assign fwft      = (mode_q == MODE_FWFT);
    assign mem_empty = (rbin == wbin_s);

    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
        end
    end

    // state register
    always_ff @(posedge rclk) begin
        if (clr) begin
            state <= RS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and load decision
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        if (rt) begin
            state_nx = RS_REWIND;
        end else begin
            unique case (state)
                RS_IDLE: begin
                    if (fwft) begin
                        if (!mem_empty) begin
                            load     = 1'b1;
                            state_nx = RS_LOADED;
                        end
                    end else if (rd_en && !mem_empty) begin
                        load = 1'b1;
                    end
                end
                RS_LOADED: begin
                    if (rd_en) begin
                        if (!mem_empty) begin
                            load = 1'b1;
                        end else begin
                            state_nx = RS_IDLE;
                        end
                    end
                end
                RS_REWIND: begin
                    state_nx = RS_IDLE;
                end
            endcase
        end
    end

    // flag outputs
    always_comb begin
        unique case (state)
            RS_IDLE:   stat_rd_n = fwft ? 1'b1 : !mem_empty;
            RS_LOADED: stat_rd_n = 1'b0;
            RS_REWIND: stat_rd_n = fwft;
        endcase
    end

    assign rbin_nx = rt ? '0 : (load ? rbin + 1'b1 : rbin);

    always_ff @(posedge rclk) begin
        if (clr) begin
            rbin  <= '0;
            rgray <= '0;
            rd_q  <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            if (load) begin
                rd_q <= mem_q;
            end
        end
    end

    assign raddr = rbin[AW-1:0];

    // R10
    rd_blocked_chk: assert property (@(posedge rclk) disable iff (clr)
        (!fwft && mem_empty && !rt) |=> $stable(rbin));

    // R8
    rd_hold_chk: assert property (@(posedge rclk) disable iff (clr)
        (!fwft && !rd_en && !rt) |=> ($stable(rbin) && $stable(rd_q)));

    // R7
    rewind_ptr_chk: assert property (@(posedge rclk) disable iff (clr)
        rt |=> (rbin == '0 && stat_rd_n == fwft));

    // R9
    fall_hold_chk: assert property (@(posedge rclk) disable iff (clr)
        (state == RS_LOADED && !rd_en && !rt) |=> ($stable(rd_q) && !stat_rd_n));
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             fwft_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rt,
    input  logic             oe,
    output logic [WIDTH-1:0] rd_data,
    output logic             stat_rd_n,
    output logic             stat_wr_n,
    output logic             half_full
);
    localparam int PW = AW + 1;

    logic             clr;
    logic [PW-1:0]    wgray;
    logic [PW-1:0]    rgray;
    logic [PW-1:0]    wbin_s;
    logic [PW-1:0]    rbin_s;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic             wr_go;
    logic [WIDTH-1:0] mem_q;
    logic [WIDTH-1:0] rd_q;

    assign clr = !mrst_n || !prst_n;

    rwf_gray_xfer #(.PW(PW)) u_w2r (
        .clk(rclk), .clr(clr), .gray_in(wgray), .bin_out(wbin_s)
    );

    rwf_gray_xfer #(.PW(PW)) u_r2w (
        .clk(wclk), .clr(clr), .gray_in(rgray), .bin_out(rbin_s)
    );

    rwf_mem #(.AW(AW), .WIDTH(WIDTH)) u_mem (
        .wclk(wclk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_q)
    );

    rwf_wside #(.AW(AW)) u_wside (
        .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
        .wr_en(wr_en), .rbin_s(rbin_s), .wgray(wgray), .waddr(waddr),
        .wr_go(wr_go), .stat_wr_n(stat_wr_n), .half_full(half_full)
    );

    rwf_rside #(.AW(AW), .WIDTH(WIDTH)) u_rside (
        .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
        .rd_en(rd_en), .rt(rt), .wbin_s(wbin_s), .mem_q(mem_q),
        .rgray(rgray), .raddr(raddr), .rd_q(rd_q), .stat_rd_n(stat_rd_n)
    );

    assign rd_data = oe ? rd_q : '0;
endmodule

// File: tb/rewind_fifo_tb.sv
module rewind_fifo_tb;
    localparam int WIDTH = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    always #4 wclk = ~wclk;
    always #5 rclk = ~rclk;

    logic             mrst_n   = 1'b0;
    logic             prst_n   = 1'b1;
    logic             fwft_sel = 1'b0;
    logic             wr_en    = 1'b0;
    logic [WIDTH-1:0] wr_data  = '0;
    logic             rd_en    = 1'b0;
    logic             rt       = 1'b0;
    logic             oe       = 1'b1;
    logic [WIDTH-1:0] rd_data;
    logic             stat_rd_n;
    logic             stat_wr_n;
    logic             half_full;

    int errors = 0;
    int checks = 0;
    bit fwft   = 1'b0;
    logic [WIDTH-1:0] sb[$];
    logic [WIDTH-1:0] hist[$];

    rewind_fifo #(.WIDTH(WIDTH), .AW(AW)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_sel(fwft_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rt(rt), .oe(oe), .rd_data(rd_data), .stat_rd_n(stat_rd_n),
        .stat_wr_n(stat_wr_n), .half_full(half_full)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic master_reset(input bit to_fwft);
        @(negedge wclk);
        mrst_n = 1'b0; fwft_sel = to_fwft;
        wr_en = 1'b0; rd_en = 1'b0; rt = 1'b0;
        repeat (4) @(negedge rclk);
        mrst_n = 1'b1;
        fwft = to_fwft;
        @(negedge rclk);
        fwft_sel = ~to_fwft;   // must be ignored from here on
        sb.delete(); hist.delete();
        repeat (4) @(negedge rclk);
    endtask

    task automatic partial_reset();
        @(negedge wclk);
        prst_n = 1'b0;
        repeat (4) @(negedge rclk);
        prst_n = 1'b1;
        sb.delete(); hist.delete();
        repeat (4) @(negedge rclk);
    endtask

    // driver: waits for room, writes one word, records it in the scoreboard
    task automatic push(input logic [WIDTH-1:0] d);
        int n = 0;
        @(negedge wclk);
        while (stat_wr_n !== (fwft ? 1'b0 : 1'b1) && n < 60) begin
            @(negedge wclk);
            n++;
        end
        if (n >= 60) chk("R3", "room to write", 32'd0, 32'd1);
        wr_en = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
        sb.push_back(d);
        hist.push_back(d);
    endtask

    // monitor: pops the expected word and compares it with the output
    task automatic pop(input string req);
        logic [WIDTH-1:0] e;
        int n = 0;
        if (sb.size() == 0) begin
            chk(req, "scoreboard underrun", 32'd0, 32'd1);
            return;
        end
        e = sb.pop_front();
        @(negedge rclk);
        while (stat_rd_n !== (fwft ? 1'b0 : 1'b1) && n < 60) begin
            @(negedge rclk);
            n++;
        end
        if (fwft) begin
            chk(req, "head word", rd_data, e);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
        end else begin
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
            chk(req, "read word", rd_data, e);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        // ---------------- standard mode ----------------
        master_reset(1'b0);
        chk("R4", "rd_data after master reset", rd_data, 0);
        chk("R2", "empty flag after reset", stat_rd_n, 0);
        chk("R2", "full flag after reset", stat_wr_n, 1);
        chk("R6", "half_full after reset", half_full, 0);

        push(8'hA5);
        settle();
        chk("R2", "not empty after write", stat_rd_n, 1);
        chk("R1", "no fall-through with select changed", rd_data, 0);
        chk("R8", "output held without rd_en", rd_data, 0);
        pop("R12");
        settle();
        chk("R2", "empty after drain", stat_rd_n, 0);

        // read while empty
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        chk("R10", "underflow leaves output", rd_data, 8'hA5);
        push(8'h3C);
        settle();
        pop("R10");

        // half-full boundary
        for (int i = 0; i < DEPTH / 2; i++) push(8'h40 + 8'(i));
        chk("R6", "half_full at DEPTH/2", half_full, 0);
        push(8'h48);
        chk("R6", "half_full above DEPTH/2", half_full, 1);
        for (int i = 0; i < DEPTH / 2 - 1; i++) push(8'h50 + 8'(i));
        chk("R2", "full flag at DEPTH", stat_wr_n, 0);

        // write while full
        @(negedge wclk); wr_en = 1'b1; wr_data = 8'hEE;
        @(negedge wclk); wr_en = 1'b0;
        chk("R10", "still full after overflow try", stat_wr_n, 0);
        settle();
        for (int i = 0; i < DEPTH; i++) pop("R12");
        settle();
        chk("R10", "empty after draining DEPTH words", stat_rd_n, 0);
        chk("R2", "not full after drain", stat_wr_n, 1);

        // output enable
        oe = 1'b0;
        push(8'h77);
        settle();
        chk("R11", "rd_data gated by oe", rd_data, 0);
        chk("R11", "flag unaffected by oe", stat_rd_n, 1);
        oe = 1'b1;
        pop("R11");

        // partial reset keeps standard mode
        partial_reset();
        chk("R5", "rd_data after partial reset", rd_data, 0);
        chk("R5", "standard empty flag kept", stat_rd_n, 0);
        chk("R5", "standard full flag kept", stat_wr_n, 1);

        // rewind in standard mode
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        settle();
        for (int i = 0; i < 3; i++) pop("R12");
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk);
        chk("R7", "empty shown during rewind", stat_rd_n, 0);
        rt = 1'b0;
        settle();
        sb = hist;
        for (int i = 0; i < 5; i++) pop("R7");
        push(8'h15);
        settle();
        pop("R7");
        settle();
        chk("R7", "empty after rewound replay", stat_rd_n, 0);

        // ---------------- fall-through mode ----------------
        master_reset(1'b1);
        chk("R4", "rd_data after master reset", rd_data, 0);
        chk("R3", "output-ready idle after reset", stat_rd_n, 1);
        chk("R3", "input-ready after reset", stat_wr_n, 0);

        push(8'h5A);
        settle();
        chk("R9", "word fell through", rd_data, 8'h5A);
        chk("R9", "output-ready asserted", stat_rd_n, 0);
        repeat (4) @(negedge rclk);
        chk("R8", "word held without rd_en", rd_data, 8'h5A);
        pop("R9");
        settle();
        chk("R3", "output-ready clear after drain", stat_rd_n, 1);

        for (int i = 0; i <= DEPTH; i++) push(8'h80 + 8'(i));
        settle();
        chk("R3", "input-ready clear when full", stat_wr_n, 1);
        chk("R6", "half_full when full", half_full, 1);
        for (int i = 0; i <= DEPTH; i++) pop("R12");
        settle();
        chk("R3", "output-ready clear after drain", stat_rd_n, 1);

        partial_reset();
        chk("R5", "fall-through ready flag kept", stat_rd_n, 1);
        chk("R5", "fall-through input-ready kept", stat_wr_n, 0);
        chk("R5", "rd_data after partial reset", rd_data, 0);

        for (int i = 0; i < 6; i++) push(8'h20 + 8'(i));
        settle();
        for (int i = 0; i < 2; i++) pop("R12");
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk);
        chk("R7", "output-ready high during rewind", stat_rd_n, 1);
        rt = 1'b0;
        settle();
        sb = hist;
        for (int i = 0; i < 6; i++) pop("R7");

        report();
        $finish;
    end
endmodule